// File: doc/BRIEF.md
# Serial status-register command front-end

This block is the serial slave front-end of a small non-volatile memory. A four-wire serial bus (clock, active-low select, data in, data out) carries 8-bit commands. The block handles the commands that manage the memory's write permission. It keeps a write-enable latch, decodes the commands that set and clear that latch, returns the status byte on request, and accepts a new status byte when permission allows it. The memory array and its data commands are handled elsewhere. They use the `write_allowed` output to learn whether a write may go ahead.

All bus pins are sampled by the system clock `clk` through two-stage synchronizers. Bus edges are detected inside the block, so the serial clock must be several times slower than `clk`. Serial clock idle-low and idle-high framing (modes 0 and 3) both work. Bits are taken on rising serial-clock edges, most significant bit first. The status byte is laid out as {protect, guard[4:0], latch, 0}. The protect bit, combined with the write-protect pin, can lock the status byte against change.

Top module: `spi_sr_front`

## Requirements
- R1: After `por_n` is low, the latch, the protect bit and the guard bits are all 0, and `write_allowed` and `so_oe` are 0.
- R2: A frame holding exactly 8 bits with opcode 0x06 sets the latch when select rises. `write_allowed` follows the latch.
- R3: A frame holding exactly 8 bits with opcode 0x04 clears the latch when select rises.
- R4: A 0x06 or 0x04 frame with any bit count other than 8 changes nothing. This includes frames cut short before 8 bits.
- R5: After the eighth rising edge of opcode 0x05, the status byte {protect, guard[4:0], latch, 0} is driven on `so`. It goes out MSB first, and a new bit is presented after each falling serial-clock edge. The byte repeats every 8 bits while select stays low. `so_oe` is 1 from the eighth rising edge until select goes high.
- R6: `so_oe` stays 0 during every frame other than a 0x05 frame, and also while select is high.
- R7: Opcode 0x01 followed by a data byte, in a frame of at least 16 bits, writes the status when select rises, provided the latch is set and writes are not locked. The protect bit takes data bit 7 and the guard bits take data bits 6:2. Data bits 1:0 are ignored. The latch is cleared at the same time.
- R8: A 0x01 frame sent while the latch is clear leaves the status unchanged.
- R9: The status byte is locked when the protect bit is 1 and `wp_n` is 0. A 0x01 frame under lock changes nothing, and the latch stays set. With `wp_n` at 1, the write proceeds as in R7.
- R10: A 0x01 frame shorter than 16 bits changes nothing, and the latch stays set.
- R11: Every command behaves the same whether the serial clock idles low (mode 0) or high (mode 3) between frames.
- R12: Opcodes other than 0x01, 0x04, 0x05 and 0x06 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| por_n | input | 1 | Active-low power-on reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| write_allowed | output | 1 | Current state of the write-enable latch |

## Verification
An incorrect latch shows up on `write_allowed` a few system clocks after select rises. It also appears in bit 1 of the next status read. A bit counter that is off by one makes single-byte commands or the data byte act on the wrong frames. That error is seen as a latch or status value that differs from the model after the very next frame. An incorrect lock decision appears on the following status read, as a status byte that should not have changed (or should have), and as a latch that stayed set or was cleared. A read pointer that slips presents bits in the wrong order on `so` within the same frame.

// File: rtl/spi_sr_front.sv
module spi_sr_front #(
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRDI = 8'h04,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WRSR = 8'h01,
  parameter int         CNT_W   = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic write_allowed
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(16);

  logic [2:0] sck_q, cs_q;
  logic [1:0] si_q;
  logic [CNT_W-1:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] opcode;
  logic [5:0] data_q;
  logic       wel, srp;
  logic [4:0] guard;
  logic       rd_active;
  logic [2:0] rd_idx;
  logic       so_q;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_hi    = cs_q[1];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire [7:0] rx_byte = {shreg, si_q[1]};
  wire [7:0] status  = {srp, guard, wel, 1'b0};
  wire locked = srp & ~wp_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      si_q  <= {si_q[0], si};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bitcnt    <= '0;
      shreg     <= '0;
      opcode    <= '0;
      data_q    <= '0;
      wel       <= 1'b0;
      srp       <= 1'b0;
      guard     <= '0;
      rd_active <= 1'b0;
      rd_idx    <= '0;
      so_q      <= 1'b0;
    end else if (cs_hi) begin
      bitcnt    <= '0;
      rd_active <= 1'b0;
      if (cs_rise) begin
        if (bitcnt == CNT_OP && opcode == OP_WREN) wel <= 1'b1;
        if (bitcnt == CNT_OP && opcode == OP_WRDI) wel <= 1'b0;
        if (bitcnt >= CNT_DATA && opcode == OP_WRSR && wel && !locked) begin
          srp   <= data_q[5];
          guard <= data_q[4:0];
          wel   <= 1'b0;
        end
      end
    end else begin
      if (sck_rise) begin
        shreg <= rx_byte[6:0];
        if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CNT_OP - 1'b1) begin
          opcode <= rx_byte;
          if (rx_byte == OP_RDSR) begin
            rd_active <= 1'b1;
            rd_idx    <= '0;
          end
        end
        if (bitcnt == CNT_DATA - 1'b1) data_q <= rx_byte[7:2];
      end
      if (sck_fall && rd_active) begin
        so_q   <= status[3'd7 - rd_idx];
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  assign so            = so_q;
  assign so_oe         = rd_active;
  assign write_allowed = wel;
endmodule

module spi_sr_front_chk (
  input logic       clk,
  input logic       por_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       write_allowed,
  input logic [7:0] opcode,
  input logic       srp,
  input logic       wel
);
  AST_SO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R6
  AST_WEL_SET_SRC: assert property (@(posedge clk) disable iff (!por_n)
    $rose(write_allowed) |-> $past(opcode) == 8'h06); // R2
  AST_WEL_CLR_SRC: assert property (@(posedge clk) disable iff (!por_n)
    $fell(write_allowed) |-> ($past(opcode) == 8'h04 || $past(opcode) == 8'h01)); // R3
  AST_SRP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(srp) |-> $past(wel)); // R8
endmodule

bind spi_sr_front spi_sr_front_chk chk_i (
  .clk(clk), .por_n(por_n), .cs_n(cs_n), .so_oe(so_oe),
  .write_allowed(write_allowed), .opcode(opcode), .srp(srp), .wel(wel)
);

// File: tb/spi_sr_front_tb_top.sv
`timescale 1ns/1ps
module spi_sr_front_tb_top;
  localparam int H = 8;
  logic clk = 1'b0, por_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, write_allowed;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] exp_sr;

  always #2.5 clk = ~clk;

  spi_sr_front dut_i (
    .clk(clk), .por_n(por_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .write_allowed(write_allowed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n * H) @(negedge clk);
  endtask

  task automatic xfer(input bit m3, input logic [23:0] d, input int n,
                      output logic [7:0] r1, output logic [7:0] r2,
                      output bit oe_early, output bit oe_all);
    r1 = '0; r2 = '0; oe_early = 0; oe_all = 1;
    @(negedge clk);
    sck = m3;
    wait_h(1);
    cs_n = 1'b0;
    wait_h(1);
    for (int i = 0; i < n; i++) begin
      if (m3) sck = 1'b0;
      si = d[23 - i];
      wait_h(1);
      if (i < 8) oe_early |= so_oe;
      else oe_all &= so_oe;
      if (i >= 8 && i < 16) r1 = {r1[6:0], so};
      if (i >= 16 && i < 24) r2 = {r2[6:0], so};
      sck = 1'b1;
      wait_h(1);
      if (!m3) sck = 1'b0;
    end
    wait_h(1);
    cs_n = 1'b1;
    wait_h(4);
    oe_early |= so_oe;
  endtask

  task automatic cmd(input bit m3, input logic [7:0] op, input int n, input string req);
    logic [7:0] a, b; bit e, o;
    xfer(m3, {op, 16'h0}, n, a, b, e, o);
    chk({req, " so_oe quiet"}, e, 0);
  endtask

  task automatic wrsr(input bit m3, input logic [7:0] dat, input int n, input string req);
    logic [7:0] a, b; bit e, o;
    xfer(m3, {8'h01, dat, 8'h0}, n, a, b, e, o);
    chk({req, " so_oe quiet"}, e, 0);
  endtask

  task automatic rdsr_chk(input bit m3, input logic [7:0] exp, input string req);
    logic [7:0] a, b; bit e, o;
    xfer(m3, 24'h050000, 24, a, b, e, o);
    chk({req, " status"}, a, exp);
    chk({req, " status repeat R5"}, b, exp);
    chk({req, " so_oe during read R5"}, o, 1);
    chk({req, " so_oe off after read R6"}, so_oe, 0);
  endtask

  task automatic t_reset;
    chk("R1 write_allowed", write_allowed, 0);
    chk("R1 so_oe", so_oe, 0);
    rdsr_chk(0, 8'h00, "R1");
  endtask

  task automatic t_latch;
    cmd(0, 8'h06, 8, "R2");
    chk("R2 write_allowed set", write_allowed, 1);
    rdsr_chk(0, 8'h02, "R2");
    cmd(1, 8'h04, 8, "R3");
    chk("R3 write_allowed clear mode3 R11", write_allowed, 0);
    cmd(1, 8'h06, 8, "R11");
    chk("R11 set in mode3", write_allowed, 1);
    rdsr_chk(1, 8'h02, "R11");
    cmd(0, 8'h04, 8, "R3");
    chk("R3 clear mode0", write_allowed, 0);
  endtask

  task automatic t_bad_len;
    cmd(0, 8'h06, 5, "R4");
    chk("R4 short wren ignored", write_allowed, 0);
    cmd(0, 8'h06, 9, "R4");
    chk("R4 long wren ignored", write_allowed, 0);
    cmd(0, 8'h06, 8, "R4");
    cmd(1, 8'h04, 6, "R4");
    chk("R4 short wrdi ignored", write_allowed, 1);
    cmd(0, 8'h04, 12, "R4");
    chk("R4 long wrdi ignored", write_allowed, 1);
  endtask

  task automatic t_unknown;
    cmd(0, 8'h9F, 8, "R12");
    chk("R12 9F no effect", write_allowed, 1);
    cmd(1, 8'h00, 8, "R12");
    chk("R12 00 no effect", write_allowed, 1);
    rdsr_chk(0, 8'h02, "R12");
  endtask

  task automatic t_wrsr;
    wrsr(0, 8'h7E, 16, "R7");
    exp_sr = 8'h7C;
    chk("R7 latch cleared", write_allowed, 0);
    rdsr_chk(0, exp_sr, "R7");
    wrsr(1, 8'h00, 16, "R8");
    rdsr_chk(1, exp_sr, "R8");
    chk("R8 latch still clear", write_allowed, 0);
    cmd(0, 8'h06, 8, "R10");
    wrsr(0, 8'h00, 12, "R10");
    chk("R10 latch kept", write_allowed, 1);
    rdsr_chk(0, exp_sr | 8'h02, "R10");
    wrsr(1, 8'h80, 20, "R11");
    exp_sr = 8'h80;
    rdsr_chk(1, exp_sr, "R11 wrsr mode3");
  endtask

  task automatic t_protect;
    wp_n = 1'b0;
    cmd(0, 8'h06, 8, "R9");
    wrsr(0, 8'h00, 16, "R9");
    chk("R9 locked latch kept", write_allowed, 1);
    rdsr_chk(0, 8'h82, "R9 locked");
    wp_n = 1'b1;
    wrsr(0, 8'h24, 16, "R9");
    chk("R9 unlocked latch cleared", write_allowed, 0);
    rdsr_chk(0, 8'h24, "R9 unlocked");
    wp_n = 1'b0;
    cmd(1, 8'h06, 8, "R9");
    wrsr(1, 8'hFC, 16, "R9");
    chk("R9 bit7 clear so write allowed", write_allowed, 0);
    rdsr_chk(1, 8'hFC, "R9 srp0 wp low");
    wp_n = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    por_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_latch;
    t_bad_len;
    t_unknown;
    t_wrsr;
    t_protect;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule